// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time for a chip: seconds, minutes, hours, day of week, day of month, month and two-digit year. It advances once for every pulse on a one-second tick input. It also holds a seconds/minutes/hours alarm and raises a pulse when the time reaches that alarm. Software reaches the seven time fields, the three alarm fields, a status byte and a control byte through a flat byte-wide register port, with combinational reads and single-cycle writes.

The control byte chooses how every field is counted. Fields can be stored as plain binary or as packed BCD. Hours can run as 0 to 23, or as 1 to 12 with a PM flag in the top bit. A hold bit freezes advancement while software rewrites the fields. Each advance is framed by an update-in-progress status, which software polls before reading the time. An update-ended pulse marks the moment the fields are stable again.

Top module: `tod_calendar`

## Requirements
- R1: Register indices: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 day of week, 7 day of month, 8 month, 9 year. Index 10 is read-only status, with the update-in-progress flag in bit 7 and the other bits zero. Index 11 is the control byte. Indices 0 to 9 and 11 read back exactly what was written. Indices 12 to 15 read as zero.
- R2: Seconds and minutes step through 0 to 59. Any value at or above 59 becomes 0 on the next advance and carries into the next field. Fields are BCD when control bit 2 is clear.
- R3: With control bit 2 set, every field counts in plain binary with the same limits.
- R4: With control bit 1 set, hours run 0 to 23. Going from 23 to 0 carries into day of week and day of month.
- R5: With control bit 1 clear, hours run 12, 1, 2 ... 11, and bit 7 marks PM. Going from 11 to 12 toggles PM. Only the change from 11 PM to 12 AM carries into the day fields.
- R6: Day of month wraps to 1 after the length of the current month. February has 29 days when the binary value of the year is divisible by 4, and 28 otherwise. Month wraps from 12 to 1 with a carry into the year, and the year wraps from 99 to 0.
- R7: Day of week counts 1 to 7 and wraps from 7 to 1 on a day carry.
- R8: While control bit 7 is set, ticks are ignored: the status flag stays low and the time fields keep their values. Once the bit is cleared, ticks advance the time again.
- R9: Writing the mode bits (control bits 1 and 2) leaves the stored field values unchanged.
- R10: A tick sampled on a clock edge makes the status flag high from that edge for exactly two cycles. The fields change only at the end of the first of those cycles. A one-cycle update-ended pulse coincides with the first cycle the flag is low again.
- R11: The alarm output pulses together with the update-ended pulse exactly when the newly advanced seconds, minutes and hours bytes equal the three alarm bytes.
- R12: After reset: control is parameter RST_CTRL (default 0x02, BCD and 24-hour), time is 00:00:00, day of week 1, day 1, month 1, year 0, alarm bytes zero, and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| addr_i | input | 4 | Register index |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable for the addressed register |
| rdata_o | output | 8 | Combinational read data for addr_i |
| uip_o | output | 1 | Update in progress |
| upd_end_o | output | 1 | One-cycle pulse when an update completes |
| alarm_o | output | 1 | One-cycle pulse on alarm match |

## Verification
A wrong carry or limit in the field arithmetic shows up on the very next tick, as a wrong byte read from the affected field. For that reason the bench drives every hour value in both encodings and both hour formats, and every month-end in a leap year and a non-leap year, reading the fields back after each advance. A fault in the update sequencer shows within three cycles of a tick, as a status flag of the wrong length or a misplaced update-ended pulse. A wrong alarm comparison shows as a missing or extra alarm pulse on the same cycle as update-ended.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int ADDR_W   = 4;
    localparam int FIELD_W  = 8;
    localparam int CTRL_SET = 7;
    localparam int CTRL_BIN = 2;
    localparam int CTRL_H24 = 1;
    localparam int STAT_UIP = 7;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t year;
        field_t mon;
        field_t dom;
        field_t dow;
        field_t hour;
        field_t min;
        field_t sec;
    } tod_t;

    typedef struct packed {
        field_t hour;
        field_t min;
        field_t sec;
    } alarm_t;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 4'd0,
        A_ASEC  = 4'd1,
        A_MIN   = 4'd2,
        A_AMIN  = 4'd3,
        A_HOUR  = 4'd4,
        A_AHOUR = 4'd5,
        A_DOW   = 4'd6,
        A_DOM   = 4'd7,
        A_MON   = 4'd8,
        A_YEAR  = 4'd9,
        A_STAT  = 4'd10,
        A_CTRL  = 4'd11
    } addr_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARM,
        SEQ_SETTLE
    } seq_e;

    // stored byte -> plain number
    function automatic field_t to_num(field_t v, logic bin);
        field_t hi;
        field_t lo;
        hi = {4'd0, v[7:4]};
        lo = {4'd0, v[3:0]};
        return bin ? v : field_t'(hi * 8'd10 + lo);
    endfunction

    // plain number -> stored byte
    function automatic field_t from_num(field_t n, logic bin);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(n / 8'd10);
        ones = 4'(n % 8'd10);
        return bin ? n : {tens, ones};
    endfunction

    function automatic field_t wrap_next(field_t n, field_t lo, field_t hi);
        return (n >= hi) ? lo : field_t'(n + 8'd1);
    endfunction

    function automatic field_t month_len(field_t mon, field_t yr);
        case (mon)
            8'd2:                     return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/tod_seq.sv
module tod_seq
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    output logic busy,
    output logic step,
    output logic fin
);
    seq_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_IDLE;
        end else begin
            case (st_q)
                SEQ_IDLE:   if (tick && !hold) st_q <= SEQ_ARM;
                SEQ_ARM:    st_q <= SEQ_SETTLE;
                SEQ_SETTLE: st_q <= SEQ_IDLE;
                default:    st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy = (st_q != SEQ_IDLE);
    assign step = (st_q == SEQ_ARM);
    assign fin  = (st_q == SEQ_SETTLE);
endmodule

// File: rtl/tod_advance.sv
module tod_advance
    import tod_pkg::*;
(
    input  tod_t cur,
    input  logic bin,
    input  logic h24,
    output tod_t nxt
);
    field_t s_n, m_n, hr_n, mon_n, yr_n, dom_lim, h12, h_raw, h_enc;
    logic   roll_min, roll_hr, roll_day, roll_mon, roll_yr;
    logic   hr_carry, pm_n;

    assign s_n   = to_num(cur.sec, bin);
    assign m_n   = to_num(cur.min, bin);
    assign hr_n  = to_num(cur.hour, bin);
    assign h12   = to_num({1'b0, cur.hour[6:0]}, bin);
    assign mon_n = to_num(cur.mon, bin);
    assign yr_n  = to_num(cur.year, bin);
    assign dom_lim = month_len(mon_n, yr_n);

    // hour step, both formats
    always_comb begin
        pm_n     = cur.hour[7];
        hr_carry = 1'b0;
        h_raw    = '0;
        if (h24) begin
            hr_carry = (hr_n >= 8'd23);
            h_enc    = from_num(wrap_next(hr_n, 8'd0, 8'd23), bin);
        end else begin
            if (h12 == 8'd11) begin
                h_raw    = 8'd12;
                hr_carry = cur.hour[7];
                pm_n     = ~cur.hour[7];
            end else if (h12 >= 8'd12) begin
                h_raw = 8'd1;
            end else begin
                h_raw = field_t'(h12 + 8'd1);
            end
            h_enc = from_num(h_raw, bin);
            h_enc = {pm_n, h_enc[6:0]};
        end
    end

    assign roll_min = (s_n >= 8'd59);
    assign roll_hr  = roll_min && (m_n >= 8'd59);
    assign roll_day = roll_hr && hr_carry;
    assign roll_mon = roll_day && (to_num(cur.dom, bin) >= dom_lim);
    assign roll_yr  = roll_mon && (mon_n >= 8'd12);

    always_comb begin
        nxt     = cur;
        nxt.sec = from_num(wrap_next(s_n, 8'd0, 8'd59), bin);
        if (roll_min) nxt.min  = from_num(wrap_next(m_n, 8'd0, 8'd59), bin);
        if (roll_hr)  nxt.hour = h_enc;
        if (roll_day) begin
            nxt.dow = from_num(wrap_next(to_num(cur.dow, bin), 8'd1, 8'd7), bin);
            nxt.dom = from_num(wrap_next(to_num(cur.dom, bin), 8'd1, dom_lim), bin);
        end
        if (roll_mon) nxt.mon  = from_num(wrap_next(mon_n, 8'd1, 8'd12), bin);
        if (roll_yr)  nxt.year = from_num(wrap_next(yr_n, 8'd0, 8'd99), bin);
    end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
    import tod_pkg::*;
#(
    parameter logic [7:0] RST_CTRL = 8'h02
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_tick_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [FIELD_W-1:0] wdata_i,
    input  logic               we_i,
    output logic [FIELD_W-1:0] rdata_o,
    output logic               uip_o,
    output logic               upd_end_o,
    output logic               alarm_o
);
    tod_t   tm_q, tm_nxt;
    alarm_t al_q;
    field_t ctrl_q;
    logic   busy, step, fin, end_q, alarm_q, match;

    tod_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .tick (sec_tick_i),
        .hold (ctrl_q[CTRL_SET]),
        .busy (busy),
        .step (step),
        .fin  (fin)
    );

    tod_advance u_adv (
        .cur (tm_q),
        .bin (ctrl_q[CTRL_BIN]),
        .h24 (ctrl_q[CTRL_H24]),
        .nxt (tm_nxt)
    );

    assign match = (tm_q.sec == al_q.sec) && (tm_q.min == al_q.min) &&
                   (tm_q.hour == al_q.hour);

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q    <= '{year: 8'h00, mon: 8'h01, dom: 8'h01, dow: 8'h01,
                         hour: 8'h00, min: 8'h00, sec: 8'h00};
            al_q    <= '0;
            ctrl_q  <= RST_CTRL;
            end_q   <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            if (step) tm_q <= tm_nxt;
            if (we_i) begin
                case (addr_e'(addr_i))
                    A_SEC:   tm_q.sec  <= wdata_i;
                    A_ASEC:  al_q.sec  <= wdata_i;
                    A_MIN:   tm_q.min  <= wdata_i;
                    A_AMIN:  al_q.min  <= wdata_i;
                    A_HOUR:  tm_q.hour <= wdata_i;
                    A_AHOUR: al_q.hour <= wdata_i;
                    A_DOW:   tm_q.dow  <= wdata_i;
                    A_DOM:   tm_q.dom  <= wdata_i;
                    A_MON:   tm_q.mon  <= wdata_i;
                    A_YEAR:  tm_q.year <= wdata_i;
                    A_CTRL:  ctrl_q    <= wdata_i;
                    default: ;
                endcase
            end
            end_q   <= fin;
            alarm_q <= fin && match;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_e'(addr_i))
            A_SEC:   rdata_o = tm_q.sec;
            A_ASEC:  rdata_o = al_q.sec;
            A_MIN:   rdata_o = tm_q.min;
            A_AMIN:  rdata_o = al_q.min;
            A_HOUR:  rdata_o = tm_q.hour;
            A_AHOUR: rdata_o = al_q.hour;
            A_DOW:   rdata_o = tm_q.dow;
            A_DOM:   rdata_o = tm_q.dom;
            A_MON:   rdata_o = tm_q.mon;
            A_YEAR:  rdata_o = tm_q.year;
            A_STAT:  rdata_o[STAT_UIP] = busy;
            A_CTRL:  rdata_o = ctrl_q;
            default: rdata_o = '0;
        endcase
    end

    assign uip_o     = busy;
    assign upd_end_o = end_q;
    assign alarm_o   = alarm_q;
endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
    import tod_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic uip,
    input logic upd_end,
    input logic alarm,
    input logic we,
    input logic set_bit,
    input tod_t tm
);
    AST_END_ON_UIP_FALL: assert property (@(posedge clk) disable iff (rst)
        upd_end |-> $fell(uip)); // R10
    AST_UIP_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(uip) |=> uip); // R10
    AST_UIP_MAX_TWO: assert property (@(posedge clk) disable iff (rst)
        (uip && $past(uip)) |=> !uip); // R10
    AST_TIME_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!uip && !we) |=> $stable(tm)); // R10
    AST_ALARM_WITH_END: assert property (@(posedge clk) disable iff (rst)
        alarm |-> upd_end); // R11
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (rst)
        (set_bit && !uip) |=> !uip); // R8
endmodule

bind tod_calendar tod_calendar_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .uip     (uip_o),
    .upd_end (upd_end_o),
    .alarm   (alarm_o),
    .we      (we_i),
    .set_bit (ctrl_q[tod_pkg::CTRL_SET]),
    .tm      (tm_q)
);

// File: tb/tod_calendar_tb.sv
module tod_calendar_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic       uip, upd_end, alarm;

    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] cur_ctrl = 8'h02;
    logic alarm_seen;

    always #5 clk = ~clk;

    tod_calendar u_dut (
        .clk        (clk),
        .rst        (rst),
        .sec_tick_i (tick),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .we_i       (we),
        .rdata_o    (rdata),
        .uip_o      (uip),
        .upd_end_o  (upd_end),
        .alarm_o    (alarm)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input int n, input bit bin);
        return bin ? 8'(n) : 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [7:0] enc12(input int k, input bit bin);
        int hr;
        hr = (k % 12 == 0) ? 12 : k % 12;
        return (k >= 12 ? 8'h80 : 8'h00) | enc(hr, bin);
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = 4'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic expect_reg(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = 4'(a);
        #1;
        check(rdata === exp, tag, int'(rdata), int'(exp));
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        wr(11, c);
        cur_ctrl = c;
    endtask

    task automatic load(input logic [7:0] s, m, h, w, d, mo, y);
        wr(11, cur_ctrl | 8'h80);
        wr(0, s); wr(2, m); wr(4, h); wr(6, w); wr(7, d); wr(8, mo); wr(9, y);
        wr(11, cur_ctrl);
    endtask

    // one tick with sequencer timing checks
    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1; addr = 4'd10;
        @(negedge clk);
        tick = 1'b0;
        #1;
        check(uip === 1'b1, "R10 uip first cycle", uip, 1);
        check(rdata[7] === 1'b1, "R1 status bit7 during update", rdata[7], 1);
        @(negedge clk);
        check(uip === 1'b1 && upd_end === 1'b0, "R10 uip second cycle", {uip, upd_end}, 2);
        @(negedge clk);
        check(uip === 1'b0 && upd_end === 1'b1, "R10 end pulse", {uip, upd_end}, 1);
        alarm_seen = alarm;
        @(negedge clk);
        check(upd_end === 1'b0 && alarm === 1'b0, "R10 R11 pulses one cycle", {upd_end, alarm}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        #1;
        check({uip, upd_end, alarm} === 3'b000, "R12 outputs low", {uip, upd_end, alarm}, 0);
        expect_reg(11, 8'h02, "R12 control");
        expect_reg(0, 8'h00, "R12 seconds");
        expect_reg(4, 8'h00, "R12 hours");
        expect_reg(6, 8'h01, "R12 day of week");
        expect_reg(7, 8'h01, "R12 day of month");
        expect_reg(8, 8'h01, "R12 month");
        expect_reg(9, 8'h00, "R12 year");
        expect_reg(5, 8'h00, "R12 alarm hours");
        expect_reg(10, 8'h00, "R1 status idle");

        // R1 register map readback
        wr(11, 8'h82);
        for (int i = 0; i < 10; i++) wr(i, 8'(8'h30 + i * 7));
        for (int i = 0; i < 10; i++) expect_reg(i, 8'(8'h30 + i * 7), "R1 readback");
        expect_reg(11, 8'h82, "R1 control readback");
        for (int i = 12; i < 16; i++) begin
            wr(i, 8'h5A);
            expect_reg(i, 8'h00, "R1 unused index reads zero");
        end

        // R2 BCD and R3 binary seconds/minutes sweep
        for (int b = 0; b < 2; b++) begin
            set_ctrl(b ? 8'h06 : 8'h02);
            load(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
            for (int n = 1; n <= 125; n++) begin
                do_tick();
                expect_reg(0, enc(n % 60, b[0]), b ? "R3 seconds binary" : "R2 seconds BCD");
                expect_reg(2, enc(n / 60, b[0]), b ? "R3 minutes binary" : "R2 minutes BCD");
            end
        end

        // R4 24-hour sweep, both encodings
        for (int b = 0; b < 2; b++) begin
            set_ctrl(b ? 8'h06 : 8'h02);
            for (int h = 0; h < 24; h++) begin
                load(enc(59, b[0]), enc(59, b[0]), enc(h, b[0]), 8'h03, enc(5, b[0]), enc(6, b[0]), enc(10, b[0]));
                do_tick();
                expect_reg(4, enc((h + 1) % 24, b[0]), "R4 hour step");
                expect_reg(7, enc(h == 23 ? 6 : 5, b[0]), "R4 day carry");
                expect_reg(0, 8'h00, "R2 seconds wrap");
            end
        end

        // R5 12-hour sweep, both encodings
        for (int b = 0; b < 2; b++) begin
            set_ctrl(b ? 8'h04 : 8'h00);
            for (int k = 0; k < 24; k++) begin
                load(enc(59, b[0]), enc(59, b[0]), enc12(k, b[0]), 8'h02, enc(9, b[0]), enc(3, b[0]), enc(20, b[0]));
                do_tick();
                expect_reg(4, enc12((k + 1) % 24, b[0]), "R5 12h step");
                expect_reg(7, enc(k == 23 ? 10 : 9, b[0]), "R5 day carry only at midnight");
            end
        end

        // R6 month ends, leap and non-leap years
        set_ctrl(8'h02);
        for (int y = 4; y < 6; y++) begin
            for (int m = 1; m <= 12; m++) begin
                load(8'h59, 8'h59, 8'h23, 8'h01, enc(mlen(m, y) - 1, 0), enc(m, 0), enc(y, 0));
                do_tick();
                expect_reg(7, enc(mlen(m, y), 0), "R6 no wrap before month end");
                load(8'h59, 8'h59, 8'h23, 8'h01, enc(mlen(m, y), 0), enc(m, 0), enc(y, 0));
                do_tick();
                expect_reg(7, 8'h01, "R6 day wraps");
                expect_reg(8, enc(m % 12 + 1, 0), "R6 month step");
                expect_reg(9, enc(m == 12 ? y + 1 : y, 0), "R6 year carry");
            end
        end
        load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick();
        expect_reg(9, 8'h00, "R6 year 99 wraps");
        expect_reg(8, 8'h01, "R6 month wraps");
        expect_reg(6, 8'h01, "R7 day of week wraps");
        // binary leap February (year 8)
        set_ctrl(8'h06);
        load(8'd59, 8'd59, 8'd23, 8'd6, 8'd28, 8'd2, 8'd8);
        do_tick();
        expect_reg(7, 8'd29, "R6 binary leap February");
        expect_reg(6, 8'd7, "R7 day of week step");

        // R8 hold bit
        set_ctrl(8'h02);
        load(8'h30, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
        set_ctrl(8'h82);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            check(uip === 1'b0 && upd_end === 1'b0, "R8 no update while held", {uip, upd_end}, 0);
            @(negedge clk);
        end
        expect_reg(0, 8'h30, "R8 seconds frozen");
        set_ctrl(8'h02);
        do_tick();
        expect_reg(0, 8'h31, "R8 counting resumes");

        // R9 mode change keeps raw values
        load(8'h45, 8'h10, 8'h15, 8'h01, 8'h01, 8'h01, 8'h00);
        set_ctrl(8'h04);
        expect_reg(0, 8'h45, "R9 seconds unchanged");
        expect_reg(4, 8'h15, "R9 hours unchanged");
        set_ctrl(8'h02);
        expect_reg(4, 8'h15, "R9 hours unchanged after restore");

        // R11 alarm
        load(8'h29, 8'h14, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(1, 8'h30); wr(3, 8'h14); wr(5, 8'h08);
        do_tick();
        check(alarm_seen === 1'b1, "R11 alarm on match", alarm_seen, 1);
        do_tick();
        check(alarm_seen === 1'b0, "R11 no alarm past match", alarm_seen, 0);
        load(8'h29, 8'h14, 8'h09, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(5, 8'h08);
        do_tick();
        check(alarm_seen === 1'b0, "R11 no alarm on hour mismatch", alarm_seen, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule